// File: doc/BRIEF.md
# Port-Aware Issue Arbiter

This block is the select half of an issue stage whose operands come from two register arrays: a small fast register cache and a slower full register file. Each has its own pool of read ports. Each cycle it takes the vector of ready instructions in the issue window and a per-entry flag that says both source operands sit in the register cache. It then picks up to one instruction per functional unit. For every pick it reserves the unit and a pair of read ports from one of the two arrays.

Picking runs through a stack of identical stages, one per functional unit. A stage takes the requests the stages above it did not grant. It looks only at the lowest-indexed remaining entry. If that entry's operands are cached and a cache port pair is still free, the entry is granted with cache ports. Otherwise it is granted with full-file ports, if a full-file pair is free. If neither holds, the stage stalls. Two busy vectors, one per array, run down the stack beside the requests. Each reservation marks the lowest clear busy bit, so a later stage sees only the pairs that are still free. Each array has one busy bit per pair of its read ports. All busy bits start clear every cycle. The grants and the chosen port source are registered, so they appear one clock after the inputs.

Top module: `port_aware_issue_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset when no request is presented, every grant bit and every port-source bit reads 0.
- R2: Each stage grants at most one entry. Stage s owns bits [s*WS +: WS] of `grant_o`, where bit i means window entry i.
- R3: A stage grants only the lowest-indexed entry still requested after all earlier stages, and no entry is granted by more than one stage in a cycle.
- R4: When the entry considered by an enabled stage has its cached flag set and a cache port pair is free, the stage grants it with `src_rc_o[s]` = 1 (cache ports).
- R5: An entry whose cached flag is clear is granted only with full-file ports (`src_rc_o[s]` = 0). When no full-file pair is free it is not granted, and later stages still consider that same entry first, so entries above it are not granted either.
- R6: A cached entry that finds no free cache pair is granted with full-file ports if a full-file pair is free.
- R7: In one cycle the number of stages granting with cache ports never exceeds RC_RD_PORTS/2. The number granting with full-file ports never exceeds FR_RD_PORTS/2.
- R8: A stage whose functional-unit enable is low grants nothing and reserves no ports. Later stages then see the same requests and free pairs it saw.
- R9: Only requested entries are granted. With no request present, no stage grants. `src_rc_o[s]` is 0 whenever stage s grants nothing.
- R10: Grants and port sources for the inputs presented before a clock edge appear after that edge and hold for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | WS | Ready request per issue-window entry |
| cache_i | input | WS | Per entry: both source operands are in the register cache |
| fu_en_i | input | NFU | Functional unit s is available this cycle |
| grant_o | output | NFU*WS | Registered one-hot-or-zero grant per stage, stage s at [s*WS +: WS] |
| src_rc_o | output | NFU | Registered port source per stage: 1 cache ports, 0 full-file ports or no grant |

## Verification
Directed patterns come first. A single cached request and a single uncached request separate the two port sources. A block of all-cached requests larger than the cache pool shows the fall-over to full-file ports. A block of all-uncached requests larger than the full-file pool shows the stall. An uncached entry stalled below a cached one shows that the stalled winner blocks lower-priority work. Sparse request patterns and partial unit enables show whether priority and skipping come from the remaining requests or from stage position. A long pseudo-random run of requests, cached flags and enables is then compared every cycle against a counter-based model of the two port pools. This run catches any drift in how the busy vectors are counted down across the stack.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

  // Widest window or pool a function below can handle
  localparam int unsigned VEC_W = 32;

  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic {
    SRC_FULL  = 1'b0,
    SRC_CACHE = 1'b1
  } port_src_e;

  // Keep only the lowest set bit of a request vector
  function automatic vec_t first_set(input vec_t v);
    return v & (~v + vec_t'(1));
  endfunction

  // Mark the lowest clear busy bit as taken
  function automatic vec_t claim_free_slot(input vec_t busy);
    return busy | (~busy & (busy + vec_t'(1)));
  endfunction

  // True while any of the low 'sets' busy bits is still clear
  function automatic logic slot_left(input vec_t busy, input int unsigned sets);
    vec_t m;
    m = (vec_t'(1) << sets) - vec_t'(1);
    return |(~busy & m);
  endfunction

endpackage

// File: rtl/ipa_busy_mask.sv
module ipa_busy_mask
  import ipa_pkg::*;
#(
  parameter int unsigned SETS = 2
) (
  input  logic [SETS-1:0] busy_i,
  input  logic            reserve_i,
  output logic [SETS-1:0] busy_o
);

  logic [SETS-1:0] claimed;

  always_comb begin
    claimed = SETS'(claim_free_slot(vec_t'(busy_i)));
    busy_o  = reserve_i ? claimed : busy_i;
  end

endmodule

// File: rtl/ipa_leaf_stage.sv
module ipa_leaf_stage
  import ipa_pkg::*;
#(
  parameter int unsigned WS = 8
) (
  input  logic          en_i,
  input  logic [WS-1:0] req_i,
  input  logic [WS-1:0] cache_i,
  input  logic          rc_free_i,
  input  logic          fr_free_i,
  output logic [WS-1:0] grant_o,
  output logic [WS-1:0] req_left_o,
  output logic          take_rc_o,
  output logic          take_fr_o
);

  logic [WS-1:0] winner;
  logic          any_req;
  logic          winner_cached;

  always_comb begin
    winner        = WS'(first_set(vec_t'(req_i)));
    any_req       = |req_i;
    winner_cached = |(winner & cache_i);
    take_rc_o     = en_i & any_req & winner_cached & rc_free_i;
    take_fr_o     = en_i & any_req & ~take_rc_o & fr_free_i;
    grant_o       = (take_rc_o | take_fr_o) ? winner : '0;
    req_left_o    = req_i & ~grant_o;
  end

endmodule

// File: rtl/port_aware_issue_arbiter.sv
module port_aware_issue_arbiter
  import ipa_pkg::*;
#(
  parameter int unsigned WS          = 8,
  parameter int unsigned NFU         = 4,
  parameter int unsigned RC_RD_PORTS = 4,
  parameter int unsigned FR_RD_PORTS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WS-1:0]      req_i,
  input  logic [WS-1:0]      cache_i,
  input  logic [NFU-1:0]     fu_en_i,
  output logic [NFU*WS-1:0]  grant_o,
  output logic [NFU-1:0]     src_rc_o
);

  localparam int unsigned RC_SETS = RC_RD_PORTS / 2;
  localparam int unsigned FR_SETS = FR_RD_PORTS / 2;

  // Named internal events, brought out for the checker
  logic [NFU:0][WS-1:0]      req_chain;
  logic [NFU:0][RC_SETS-1:0] rc_busy;
  logic [NFU:0][FR_SETS-1:0] fr_busy;
  logic [NFU-1:0]            rc_free;
  logic [NFU-1:0]            fr_free;
  logic [NFU-1:0]            rc_take;
  logic [NFU-1:0]            fr_take;
  logic [NFU-1:0][WS-1:0]    stage_grant;

  logic [NFU-1:0][WS-1:0]    grant_q;
  logic [NFU-1:0]            src_q;

  assign req_chain[0] = req_i;
  assign rc_busy[0]   = '0;
  assign fr_busy[0]   = '0;

  for (genvar s = 0; s < NFU; s++) begin : g_stage
    assign rc_free[s] = slot_left(vec_t'(rc_busy[s]), RC_SETS);
    assign fr_free[s] = slot_left(vec_t'(fr_busy[s]), FR_SETS);

    ipa_leaf_stage #(.WS(WS)) u_leaf (
      .en_i       (fu_en_i[s]),
      .req_i      (req_chain[s]),
      .cache_i    (cache_i),
      .rc_free_i  (rc_free[s]),
      .fr_free_i  (fr_free[s]),
      .grant_o    (stage_grant[s]),
      .req_left_o (req_chain[s+1]),
      .take_rc_o  (rc_take[s]),
      .take_fr_o  (fr_take[s])
    );

    ipa_busy_mask #(.SETS(RC_SETS)) u_rc_mask (
      .busy_i    (rc_busy[s]),
      .reserve_i (rc_take[s]),
      .busy_o    (rc_busy[s+1])
    );

    ipa_busy_mask #(.SETS(FR_SETS)) u_fr_mask (
      .busy_i    (fr_busy[s]),
      .reserve_i (fr_take[s]),
      .busy_o    (fr_busy[s+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      src_q   <= '0;
    end else begin
      grant_q <= stage_grant;
      src_q   <= rc_take;
    end
  end

  assign grant_o  = grant_q;
  assign src_rc_o = src_q;

endmodule

// File: rtl/ipa_checker.sv
module ipa_checker #(
  parameter int unsigned WS          = 8,
  parameter int unsigned NFU         = 4,
  parameter int unsigned RC_RD_PORTS = 4,
  parameter int unsigned FR_RD_PORTS = 6
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [WS-1:0]                     req_i,
  input logic [WS-1:0]                     cache_i,
  input logic [NFU-1:0]                    fu_en_i,
  input logic [NFU*WS-1:0]                 grant_o,
  input logic [NFU-1:0]                    src_rc_o,
  input logic [NFU:0][WS-1:0]              req_chain,
  input logic [NFU:0][RC_RD_PORTS/2-1:0]   rc_busy,
  input logic [NFU:0][FR_RD_PORTS/2-1:0]   fr_busy,
  input logic [NFU-1:0]                    rc_free,
  input logic [NFU-1:0]                    rc_take,
  input logic [NFU-1:0]                    fr_take,
  input logic [NFU-1:0][WS-1:0]            stage_grant
);

  localparam int unsigned RC_SETS = RC_RD_PORTS / 2;
  localparam int unsigned FR_SETS = FR_RD_PORTS / 2;

  logic [WS-1:0] grant_union;
  int unsigned   granting;
  int unsigned   rc_uses;
  int unsigned   fr_uses;

  always_comb begin
    grant_union = '0;
    granting    = 0;
    rc_uses     = 0;
    fr_uses     = 0;
    for (int s = 0; s < NFU; s++) begin
      grant_union = grant_union | grant_o[s*WS +: WS];
      if (grant_o[s*WS +: WS] != '0) granting = granting + 1;
      if (rc_take[s]) rc_uses = rc_uses + 1;
      if (fr_take[s]) fr_uses = fr_uses + 1;
    end
  end

  for (genvar s = 0; s < NFU; s++) begin : g_chk
    assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o[s*WS +: WS]));

    assert_uncached_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      src_rc_o[s] |-> ((grant_o[s*WS +: WS] & $past(cache_i)) != '0));

    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fu_en_i[s]) |-> (grant_o[s*WS +: WS] == '0));

    assert_fallover_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_take[s] && ((stage_grant[s] & cache_i) != '0)) |-> !rc_free[s]);

    assert_src_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      src_rc_o[s] |-> (grant_o[s*WS +: WS] != '0));
  end

  assert_distinct_entries_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_union) == granting);

  assert_only_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_union & ~$past(req_i)) == '0);

  assert_leftover_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_chain[NFU] & ~req_i) == '0);

  assert_rc_pool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rc_busy[NFU]) == rc_uses) && (rc_uses <= RC_SETS));

  assert_fr_pool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(fr_busy[NFU]) == fr_uses) && (fr_uses <= FR_SETS));

endmodule

bind port_aware_issue_arbiter ipa_checker #(
  .WS(WS), .NFU(NFU), .RC_RD_PORTS(RC_RD_PORTS), .FR_RD_PORTS(FR_RD_PORTS)
) u_ipa_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .cache_i     (cache_i),
  .fu_en_i     (fu_en_i),
  .grant_o     (grant_o),
  .src_rc_o    (src_rc_o),
  .req_chain   (req_chain),
  .rc_busy     (rc_busy),
  .fr_busy     (fr_busy),
  .rc_free     (rc_free),
  .rc_take     (rc_take),
  .fr_take     (fr_take),
  .stage_grant (stage_grant)
);

// File: tb/port_aware_issue_arbiter_bench.sv
module port_aware_issue_arbiter_bench;

  localparam int WS      = 8;
  localparam int NFU     = 4;
  localparam int RC_PORTS = 4;
  localparam int FR_PORTS = 6;
  localparam int RC_POOL = RC_PORTS / 2;
  localparam int FR_POOL = FR_PORTS / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WS-1:0]     req_i = '0;
  logic [WS-1:0]     cache_i = '0;
  logic [NFU-1:0]    fu_en_i = '0;
  logic [NFU*WS-1:0] grant_o;
  logic [NFU-1:0]    src_rc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  port_aware_issue_arbiter #(
    .WS(WS), .NFU(NFU), .RC_RD_PORTS(RC_PORTS), .FR_RD_PORTS(FR_PORTS)
  ) u_port_aware_issue_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cache_i(cache_i),
    .fu_en_i(fu_en_i), .grant_o(grant_o), .src_rc_o(src_rc_o)
  );

  task automatic check_all_zero(input string tag);
    checks++;
    if (grant_o != '0 || src_rc_o != '0) begin
      errors++;
      $display("FAIL %s idle outputs act grant=%h src=%b exp grant=0 src=0",
               tag, grant_o, src_rc_o);
    end
  endtask

  // Reference: pools as counters, queue of pending entry numbers
  task automatic apply(input logic [WS-1:0] r, input logic [WS-1:0] c,
                       input logic [NFU-1:0] e, input string tag);
    int rc_left;
    int fr_left;
    int pending[$];
    logic [WS-1:0] exp_g [NFU];
    logic          exp_s [NFU];
    rc_left = RC_POOL;
    fr_left = FR_POOL;
    for (int i = 0; i < WS; i++) if (r[i]) pending.push_back(i);
    for (int s = 0; s < NFU; s++) begin
      exp_g[s] = '0;
      exp_s[s] = 1'b0;
      if (e[s] && pending.size() > 0) begin
        int head;
        head = pending[0];
        if (c[head] && rc_left > 0) begin
          rc_left--;
          exp_g[s][head] = 1'b1;
          exp_s[s] = 1'b1;
          void'(pending.pop_front());
        end else if (fr_left > 0) begin
          fr_left--;
          exp_g[s][head] = 1'b1;
          void'(pending.pop_front());
        end
      end
    end
    req_i   = r;
    cache_i = c;
    fu_en_i = e;
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < NFU; s++) begin
      checks++;
      if (grant_o[s*WS +: WS] !== exp_g[s] || src_rc_o[s] !== exp_s[s]) begin
        errors++;
        $display("FAIL %s stage %0d act grant=%b src=%b exp grant=%b src=%b",
                 tag, s, grant_o[s*WS +: WS], src_rc_o[s], exp_g[s], exp_s[s]);
      end
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    check_all_zero("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all_zero("R1");

    apply(8'b0000_0000, 8'b0000_0000, 4'b1111, "R9");
    apply(8'b0000_0100, 8'b0000_0100, 4'b1111, "R4");
    apply(8'b0000_0100, 8'b0000_0000, 4'b1111, "R5");
    apply(8'b1010_0100, 8'b0000_0000, 4'b1111, "R3");
    apply(8'b0000_1111, 8'b0000_1111, 4'b1111, "R6");
    apply(8'b0011_1111, 8'b0000_0000, 4'b1111, "R5");
    apply(8'b0001_1111, 8'b0001_0000, 4'b1111, "R5");
    apply(8'b1111_0000, 8'b1010_0000, 4'b1111, "R4");
    apply(8'b1111_1111, 8'b1111_1111, 4'b0000, "R8");
    apply(8'b0110_0110, 8'b0100_0010, 4'b0101, "R8");
    apply(8'b1111_1111, 8'b0000_0001, 4'b1111, "R7");
    // back-to-back changes: each result lasts one cycle
    apply(8'b1000_0000, 8'b1000_0000, 4'b0001, "R10");
    apply(8'b0000_0001, 8'b0000_0000, 4'b1000, "R10");
    apply(8'b0000_0000, 8'b1111_1111, 4'b1111, "R10");

    for (int n = 0; n < 400; n++) begin
      logic [WS-1:0] rr;
      logic [WS-1:0] cc;
      logic [NFU-1:0] ee;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rr = lfsr[7:0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cc = lfsr[15:8] | lfsr[7:0];
      ee = lfsr[3:0] | lfsr[11:8];
      apply(rr, cc, ee, "R7");
    end

    rst_n = 1'b0;
    @(negedge clk);
    check_all_zero("R1");
    finish_run();
  end

endmodule